// File: doc/BRIEF.md
# Accumulator Adder with Condition Flags

This block performs the 8-bit add step of a small accumulator-style core. Each operation adds an operand to one of two accumulators, called A and B. The operand has already been fetched and arrives on a bus. The operation either ignores the carry flag or uses it as the carry input. The modular sum is written back to the chosen accumulator. In the same clock edge a condition register is updated with half-carry, negative, zero, overflow and carry.

Carry, half-carry and overflow are not read from an adder's carry-out. Each comes from a fixed sum-of-products expression over bit 7 (or bit 3) of the accumulator input, the operand and the result. Half-carry is kept as a flag of its own. The surrounding core drives a one-cycle strobe together with the operation select, the accumulator select and the operand. The new accumulator and flag values appear after that clock edge.

Top module: `acc_add_unit`

## Requirements
- R1: On a clock edge with `op_vld` high, the selected accumulator (`acc_sel` 0 selects A, 1 selects B) takes (accumulator + operand + carry-in) mod 256, and the other accumulator keeps its value.
- R2: With `op_carry` low, the carry-in is 0. Result and flags are the same whether the carry flag was 0 or 1 beforehand.
- R3: With `op_carry` high, the carry-in equals the carry flag held before the edge.
- R4: N takes bit 7 of the result. Z is 1 exactly when all eight result bits are 0.
- R5: C = X7·M7 + M7·¬R7 + ¬R7·X7 (X is the accumulator input, M the operand, R the result). This equals the carry out of the 8-bit sum.
- R6: H uses the same expression on bit 3. It equals the carry out of the low nibble, including the carry-in.
- R7: V = X7·M7·¬R7 + ¬X7·¬M7·R7. This is two's-complement overflow of the signed sum.
- R8: The flag register `ccr` holds ones in bits 7 and 6, H in bit 5, the interrupt-mask bit I in bit 4, N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. Reset sets I to 1, and no add operation changes it.
- R9: On an edge with `op_vld` low, the accumulators and `ccr` keep their values, whatever the other inputs are.
- R10: A synchronous reset (`rst` high at an edge) clears A, B, H, N, Z, V and C, so `ccr` reads 0xD0. Reset takes priority over `op_vld`.
- R11: 0x7F+0x01 gives 0x80 with `ccr` 0xFA. 0x80+0x80 gives 0x00 with 0xD7. 0xF0+0x20 gives 0x10 with 0xD1. 0x0F+0x01 gives 0x10 with 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_vld | input | 1 | Add-operation strobe for this cycle |
| op_carry | input | 1 | 0: add without carry, 1: add with carry flag |
| acc_sel | input | 1 | Destination and source accumulator: 0 = A, 1 = B |
| operand | input | DATA_W (8) | Fetched addend |
| acc_a | output | DATA_W (8) | Accumulator A |
| acc_b | output | DATA_W (8) | Accumulator B |
| ccr | output | 8 | Condition register: 1,1,H,I,N,Z,V,C from bit 7 down |

## Verification
On every clock, the assertions compare the written accumulator and each arithmetic flag with a plain wide addition, a nibble addition and a signed-overflow test. They also check that the unselected accumulator and every idle cycle hold their values, and that the fixed and I bits never move. What only the bench's scenarios can show is that every accumulator/operand pair has been covered: through an Euler walk it reaches all 65,536 pairs with carry-in 0 and again with carry-in 1. The bench also checks that the four named vectors give exact register values, and that reset wins over a simultaneous strobe.

// File: rtl/acc_add_pkg.sv
package acc_add_pkg;

  localparam int NUM_ACC = 2;
  localparam int CCR_W   = 8;

  // condition register bit positions (fixed layout seen by the core)
  localparam int CCR_C = 0;
  localparam int CCR_V = 1;
  localparam int CCR_Z = 2;
  localparam int CCR_N = 3;
  localparam int CCR_I = 4;
  localparam int CCR_H = 5;
  localparam logic [CCR_W-1:0] CCR_ONES = 8'hC0;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  // carry-style flag from two input bits and the result bit
  function automatic logic sop_carry(input logic a, input logic b, input logic r);
    return (a & b) | (b & ~r) | (~r & a);
  endfunction

  // overflow flag from the two sign bits and the result sign
  function automatic logic sop_ovf(input logic a, input logic b, input logic r);
    return (a & b & ~r) | (~a & ~b & r);
  endfunction

endpackage

// File: rtl/acc_add_core.sv
module acc_add_core
  import acc_add_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] m_i,
  input  logic         cin_i,
  output logic [W-1:0] r_o,
  output flags_t       flg_o
);

  localparam int MSB = W - 1;
  localparam int HB  = W / 2 - 1;

  logic [W-1:0] res;

  always_comb begin
    res = x_i + m_i + {{(W-1){1'b0}}, cin_i};
  end

  assign r_o = res;

  always_comb begin
    flg_o.n = res[MSB];
    flg_o.z = ~|res;
    flg_o.c = sop_carry(x_i[MSB], m_i[MSB], res[MSB]);
    flg_o.h = sop_carry(x_i[HB], m_i[HB], res[HB]);
    flg_o.v = sop_ovf(x_i[MSB], m_i[MSB], res[MSB]);
  end

endmodule

// File: rtl/acc_add_regfile.sv
module acc_add_regfile #(
  parameter int W = 8,
  parameter int N = 2,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_i,
  input  logic [SW-1:0]       sel_i,
  input  logic [W-1:0]        wdata_i,
  output logic [W-1:0]        rdata_o,
  output logic [N-1:0][W-1:0] acc_o
);

  for (genvar g = 0; g < N; g++) begin : g_acc
    logic [W-1:0] q;
    logic         hit;

    assign hit = we_i && (sel_i == SW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (hit) begin
        q <= wdata_i;
      end
    end

    assign acc_o[g] = q;
  end

  assign rdata_o = acc_o[sel_i];

endmodule

// File: rtl/acc_add_ccr.sv
module acc_add_ccr
  import acc_add_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  flags_t           flg_i,
  output flags_t           flg_o,
  output logic [CCR_W-1:0] ccr_o
);

  flags_t q;
  logic   mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      mask_q <= 1'b1;
    end else if (we_i) begin
      q <= flg_i;
    end
  end

  assign flg_o = q;

  always_comb begin
    ccr_o        = CCR_ONES;
    ccr_o[CCR_H] = q.h;
    ccr_o[CCR_I] = mask_q;
    ccr_o[CCR_N] = q.n;
    ccr_o[CCR_Z] = q.z;
    ccr_o[CCR_V] = q.v;
    ccr_o[CCR_C] = q.c;
  end

endmodule

// File: rtl/acc_add_unit.sv
module acc_add_unit
  import acc_add_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_vld,
  input  logic              op_carry,
  input  logic              acc_sel,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc_a,
  output logic [DATA_W-1:0] acc_b,
  output logic [7:0]        ccr
);

  // named internal events, observed by the bound checker
  logic [DATA_W-1:0]              x_sel;
  logic                           cin_eff;
  logic [DATA_W-1:0]              sum_res;
  flags_t                         flg_next;
  flags_t                         flg_q;
  logic [NUM_ACC-1:0][DATA_W-1:0] acc_all;

  assign cin_eff = op_carry & flg_q.c;

  acc_add_regfile #(
    .W (DATA_W),
    .N (NUM_ACC)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .we_i    (op_vld),
    .sel_i   (acc_sel),
    .wdata_i (sum_res),
    .rdata_o (x_sel),
    .acc_o   (acc_all)
  );

  acc_add_core #(
    .W (DATA_W)
  ) core_i (
    .x_i   (x_sel),
    .m_i   (operand),
    .cin_i (cin_eff),
    .r_o   (sum_res),
    .flg_o (flg_next)
  );

  acc_add_ccr flags_i (
    .clk   (clk),
    .rst   (rst),
    .we_i  (op_vld),
    .flg_i (flg_next),
    .flg_o (flg_q),
    .ccr_o (ccr)
  );

  assign acc_a = acc_all[0];
  assign acc_b = acc_all[1];

endmodule

// File: rtl/acc_add_chk.sv
module acc_add_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         op_vld,
  input logic         op_carry,
  input logic         acc_sel,
  input logic [W-1:0] operand,
  input logic [W-1:0] x_sel,
  input logic         cin_eff,
  input logic [W-1:0] acc_a,
  input logic [W-1:0] acc_b,
  input logic [7:0]   ccr
);

  localparam int HW = W / 2;

  logic [W:0]   wide_sum;
  logic [HW:0]  nib_sum;
  logic [W-1:0] plain_sum;
  logic [W-1:0] carry_sum;
  logic         ovf_ref;

  always_comb begin
    wide_sum  = {1'b0, x_sel} + {1'b0, operand} + {{W{1'b0}}, cin_eff};
    nib_sum   = {1'b0, x_sel[HW-1:0]} + {1'b0, operand[HW-1:0]} + {{HW{1'b0}}, cin_eff};
    plain_sum = x_sel + operand;
    carry_sum = x_sel + operand + {{(W-1){1'b0}}, ccr[0]};
    ovf_ref   = (x_sel[W-1] == operand[W-1]) && (wide_sum[W-1] != x_sel[W-1]);
  end

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (acc_a == '0 && acc_b == '0 && ccr == 8'hD0));

  a_r8_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (ccr[7:6] == 2'b11 && ccr[4] == 1'b1));

  a_r1_sum_written: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> (($past(acc_sel) ? acc_b : acc_a) == $past(wide_sum[W-1:0])));

  a_r1_other_holds: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> ($past(acc_sel) ? $stable(acc_a) : $stable(acc_b)));

  a_r2_add_no_carry: assert property (@(posedge clk) disable iff (rst)
    (op_vld && !op_carry) |=> (($past(acc_sel) ? acc_b : acc_a) == $past(plain_sum)));

  a_r3_adc_uses_c: assert property (@(posedge clk) disable iff (rst)
    (op_vld && op_carry) |=> (($past(acc_sel) ? acc_b : acc_a) == $past(carry_sum)));

  a_r4_negative: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> (ccr[3] == ($past(acc_sel) ? acc_b[W-1] : acc_a[W-1])));

  a_r4_zero: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> (ccr[2] == (($past(acc_sel) ? acc_b : acc_a) == '0)));

  a_r5_carry: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> (ccr[0] == $past(wide_sum[W])));

  a_r6_half_carry: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> (ccr[5] == $past(nib_sum[HW])));

  a_r7_overflow: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> (ccr[1] == $past(ovf_ref)));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !op_vld |=> ($stable(acc_a) && $stable(acc_b) && $stable(ccr)));

endmodule

bind acc_add_unit acc_add_chk #(.W(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_vld   (op_vld),
  .op_carry (op_carry),
  .acc_sel  (acc_sel),
  .operand  (operand),
  .x_sel    (x_sel),
  .cin_eff  (cin_eff),
  .acc_a    (acc_a),
  .acc_b    (acc_b),
  .ccr      (ccr)
);

// File: tb/acc_add_unit_tb_top.sv
module acc_add_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_vld = 1'b0;
  logic       op_carry = 1'b0;
  logic       acc_sel = 1'b0;
  logic [7:0] operand = 8'h00;
  logic [7:0] acc_a, acc_b, ccr;

  always #10 clk = ~clk;  // 50 MHz

  acc_add_unit dut_i (
    .clk      (clk),
    .rst      (rst),
    .op_vld   (op_vld),
    .op_carry (op_carry),
    .acc_sel  (acc_sel),
    .operand  (operand),
    .acc_a    (acc_a),
    .acc_b    (acc_b),
    .ccr      (ccr)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int m_a, m_b;
  bit m_h, m_i, m_n, m_z, m_v, m_c;
  bit cov[2][65536];
  int walk_cnt[256];

  function automatic logic [7:0] ccr_exp();
    return {2'b11, m_h, m_i, m_n, m_z, m_v, m_c};
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check8({tag, " acc_a"}, acc_a, 8'(m_a));
    check8({tag, " acc_b"}, acc_b, 8'(m_b));
    check8({tag, " ccr"}, ccr, ccr_exp());
  endtask

  task automatic model_reset();
    m_a = 0; m_b = 0;
    m_h = 0; m_n = 0; m_z = 0; m_v = 0; m_c = 0; m_i = 1;
  endtask

  task automatic model_op(input bit sel, input bit carry, input int opnd);
    int x, cin, s, r, sx, sm, ss;
    x   = sel ? m_b : m_a;
    cin = carry ? int'(m_c) : 0;
    s   = x + opnd + cin;
    r   = s % 256;
    sx  = (x > 127) ? x - 256 : x;
    sm  = (opnd > 127) ? opnd - 256 : opnd;
    ss  = sx + sm + cin;
    m_c = (s > 255);
    m_h = ((x % 16) + (opnd % 16) + cin) > 15;
    m_v = (ss > 127) || (ss < -128);
    m_n = (r > 127);
    m_z = (r == 0);
    if (sel) m_b = r; else m_a = r;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic run_op(input bit sel, input bit carry, input int opnd, input string tag);
    acc_sel  = sel;
    op_carry = carry;
    operand  = 8'(opnd);
    op_vld   = 1'b1;
    @(posedge clk);
    model_op(sel, carry, opnd);
    @(negedge clk);
    op_vld = 1'b0;
    compare_all(tag);
  endtask

  // make C = 1 through accumulator B without touching A
  task automatic force_carry();
    if (m_b < 2) run_op(1'b1, 1'b0, 8'h80, "R1 R5 B refill");
    run_op(1'b1, 1'b0, 8'hFF, "R1 R5 B carry set");
  endtask

  // Euler walk over every (accumulator, operand) pair with carry-in k
  task automatic walk(input int k);
    int root, x, t, lbl;
    root = m_a;
    x    = m_a;
    for (int i = 0; i < 256; i++) walk_cnt[i] = 0;
    while (walk_cnt[x] < 256) begin
      if (k == 1) begin
        while (!m_c) force_carry();
      end
      t   = (root - x - k) & 255;
      lbl = (t + 1 + walk_cnt[x]) & 255;
      walk_cnt[x]++;
      cov[k][x * 256 + lbl] = 1'b1;
      run_op(1'b0, k[0], lbl, k ? "R3 R4 R5 R6 R7 walk" : "R2 R4 R5 R6 R7 walk");
      x = m_a;
    end
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    rst = 1'b0;
    compare_all("R10 reset");
    check8("R10 R8 reset ccr", ccr, 8'hD0);

    // R11 named vectors on accumulator A
    run_op(1'b0, 1'b0, 8'h7F, "R1 load");
    run_op(1'b0, 1'b0, 8'h01, "R11 7F+01");
    check8("R11 7F+01 acc", acc_a, 8'h80);
    check8("R11 7F+01 ccr", ccr, 8'hFA);
    run_op(1'b0, 1'b0, 8'h80, "R11 80+80");
    check8("R11 80+80 acc", acc_a, 8'h00);
    check8("R11 80+80 ccr", ccr, 8'hD7);
    run_op(1'b0, 1'b0, 8'hF0, "R1 load");
    run_op(1'b0, 1'b0, 8'h20, "R11 F0+20");
    check8("R11 F0+20 acc", acc_a, 8'h10);
    check8("R11 F0+20 ccr", ccr, 8'hD1);
    run_op(1'b0, 1'b0, 8'hFF, "R1 load with carry out");
    check8("R5 carry set before add", {7'd0, ccr[0]}, 8'h01);
    run_op(1'b0, 1'b0, 8'h01, "R11 0F+01");
    check8("R11 R2 0F+01 acc with C=1", acc_a, 8'h10);
    check8("R11 R2 0F+01 ccr with C=1", ccr, 8'hF0);

    // R3 add-with-carry consumes C
    run_op(1'b0, 1'b0, 8'hF0, "R5 set C");
    run_op(1'b0, 1'b1, 8'h00, "R3 adc");
    check8("R3 adc 00+00+C acc", acc_a, 8'h01);
    check8("R3 adc ccr", ccr, 8'hD0);

    // R1 other accumulator untouched
    run_op(1'b1, 1'b0, 8'h33, "R1 write B");
    check8("R1 B written", acc_b, 8'h33);
    check8("R1 A untouched", acc_a, 8'h01);

    // R9 idle cycle with busy inputs
    acc_sel = 1'b1; op_carry = 1'b1; operand = 8'hFF; op_vld = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare_all("R9 idle");

    // R10 reset beats strobe
    rst = 1'b1; op_vld = 1'b1; acc_sel = 1'b0; operand = 8'h55;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0; op_vld = 1'b0;
    compare_all("R10 reset over strobe");

    // exhaustive walks
    walk(0);
    walk(1);

    begin
      int n0, n1;
      n0 = 0; n1 = 0;
      for (int i = 0; i < 65536; i++) begin
        n0 += int'(cov[0][i]);
        n1 += int'(cov[1][i]);
      end
      checks++;
      if (n0 != 65536) begin
        errors++;
        $display("FAIL R2 pairs covered actual %0d expected 65536", n0);
      end
      checks++;
      if (n1 != 65536) begin
        errors++;
        $display("FAIL R3 pairs covered actual %0d expected 65536", n1);
      end
    end

    check8("R8 fixed and mask bits", ccr & 8'hD0, 8'hD0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule